// File: doc/BRIEF.md
# Decoded Micro-Op Cache Lookup

This block is the lookup side of a cache that keeps already-decoded micro-ops. The cache is organised around 32-byte windows of code. The virtual fetch address selects one of 32 sets. All eight ways of that set are then compared in parallel. Each way describes one contiguous run of code bytes inside a window:
- a tag;
- the byte offset where the run starts and the run's byte length;
- how many of its six micro-op slots are valid;
- for every slot, the window offset of the instruction that the micro-op came from;
- the micro-op payloads themselves.

A fetch may point anywhere inside a window, so it need not be aligned. A way hits only when three things hold: its tag matches, the fetch offset lies inside the way's byte run, and the offset is exactly one of the recorded instruction starts. The block then reports which way hit and the first slot to read. It also returns the micro-ops from that slot onward, taken from that single way.

An offset can fall inside a run without matching any recorded instruction start. That is a miss, and every valid way in the set that carries the same tag is dropped, so that a fresh decode can repopulate the window. Fills arrive over a one-cycle, whole-way write port. A separate port clears any chosen group of ways in one set.

Top module: `uop_cache_lookup`

## Requirements
- R1: After reset every way is invalid, so any lookup misses, and `rsp_valid` is low until a request is made.
- R2: The fetch address is split as follows: bits [4:0] are the offset within the window, bits [9:5] select the set, and bits [47:10] are the tag. A way in another set, or with a different tag, never hits.
- R3: A way hits only when all of these hold:
  - it is valid and its tag matches;
  - `start <= offset < start + len`;
  - the offset equals a recorded instruction start in a slot below the way's count.
  A way with count 0 never hits, and an offset equal to `start + len` is outside the run. The response is registered: `rsp_valid` and the result appear in the cycle after `req_valid`.
- R4: On a hit, `rsp_way` gives the index of the hitting way and `rsp_slot` the matching slot. If several ways hit, the lowest way index is reported. If several slots match, the lowest slot is reported.
- R5: On a hit, `rsp_uop_cnt` is the way's count minus `rsp_slot`. Lane j of `rsp_uops` (bits [16j+15:16j]) carries slot `rsp_slot + j`, and the lanes beyond the count are zero. On a miss, `rsp_way`, `rsp_slot`, `rsp_uop_cnt` and `rsp_uops` are all zero.
- R6: If no way hits but some valid way with the matching tag has the offset inside its run, the result is a miss. Every valid way in that set with that tag is invalid from the next cycle on.
- R7: The invalidation in R6 leaves ways with a different tag, and all other sets, unchanged.
- R8: A fill writes the whole way in one cycle and marks it valid. In the fill, slot i's start offset is `fill_offs[5i+4:5i]` and its payload is `fill_uops[16i+15:16i]`. A lookup issued in the next cycle sees the new contents.
- R9: A lookup issued in the same cycle as a fill to the same set sees the contents from before the fill.
- R10: The invalidate port clears the ways of `inv_set` whose bits are set in `inv_way_mask`. If a fill targets one of those ways in the same cycle, the fill wins and the way ends valid with the new contents.
- R11: A lookup whose offset is not a multiple of any line size hits whenever R3 holds. Alignment plays no part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request this cycle |
| req_addr | input | 48 | Virtual fetch address |
| fill_valid | input | 1 | Write a whole way this cycle |
| fill_set | input | 5 | Set being written |
| fill_way | input | 3 | Way being written |
| fill_tag | input | 38 | Tag for the written way |
| fill_start | input | 5 | First byte offset covered by the way |
| fill_len | input | 6 | Number of bytes covered |
| fill_cnt | input | 3 | Number of valid micro-op slots (0 to 6) |
| fill_offs | input | 30 | Instruction start offset per slot, 5 bits each |
| fill_uops | input | 96 | Micro-op payload per slot, 16 bits each |
| inv_valid | input | 1 | Clear ways this cycle |
| inv_set | input | 5 | Set whose ways are cleared |
| inv_way_mask | input | 8 | One bit per way to clear |
| rsp_valid | output | 1 | Result of the previous cycle's request |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | 3 | Hitting way |
| rsp_slot | output | 3 | First slot to read |
| rsp_uop_cnt | output | 3 | Micro-ops delivered from that slot onward |
| rsp_uops | output | 96 | Delivered micro-ops, lane 0 first |

## Verification
A corrupted valid bit, tag or run boundary shows up at the ports on the first lookup that reaches the affected set. It appears as a wrong hit or a wrong miss in the very next cycle. A wrong slot offset or count shows up as a misplaced or zero payload lane, or a wrong `rsp_uop_cnt`, in that same response. A failure to drop ways after a conflict stays silent until a later lookup lands on a start of one of those ways and hits where it should miss. For that reason the bench compares every response against a reference model, over long runs that concentrate traffic on a few sets and tags.

// File: rtl/uopc_pkg.sv
package uopc_pkg;
    localparam int VA_W   = 48;
    localparam int OFF_W  = 5;
    localparam int IDX_W  = 5;
    localparam int SETS   = 1 << IDX_W;
    localparam int TAG_W  = VA_W - OFF_W - IDX_W;
    localparam int WAYS   = 8;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int UOPS   = 6;
    localparam int SLOT_W = $clog2(UOPS);
    localparam int CNT_W  = $clog2(UOPS + 1);
    localparam int LEN_W  = OFF_W + 1;
    localparam int UOP_W  = 16;

    typedef logic [UOPS-1:0][OFF_W-1:0] slot_offs_t;
    typedef logic [UOPS-1:0][UOP_W-1:0] slot_uops_t;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [OFF_W-1:0] start;
        logic [LEN_W-1:0] len;
        logic [CNT_W-1:0] cnt;
        slot_offs_t       offs;
        slot_uops_t       uops;
    } line_t;

    typedef struct packed {
        logic  valid;
        line_t body;
    } way_view_t;

    typedef struct packed {
        logic              tag_eq;
        logic              in_range;
        logic              hit;
        logic [SLOT_W-1:0] slot;
    } cmp_t;

    function automatic logic [OFF_W-1:0] addr_off(input logic [VA_W-1:0] a);
        return a[OFF_W-1:0];
    endfunction

    function automatic logic [IDX_W-1:0] addr_set(input logic [VA_W-1:0] a);
        return a[OFF_W +: IDX_W];
    endfunction

    function automatic logic [TAG_W-1:0] addr_tag(input logic [VA_W-1:0] a);
        return a[VA_W-1 : OFF_W+IDX_W];
    endfunction
endpackage

// File: rtl/uopc_store.sv
module uopc_store
    import uopc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [IDX_W-1:0]      rd_set,
    output way_view_t [WAYS-1:0]  rd_ways,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_set,
    input  logic [WAY_W-1:0]      wr_way,
    input  line_t                 wr_line,
    input  logic                  inv_en,
    input  logic [IDX_W-1:0]      inv_set,
    input  logic [WAYS-1:0]       inv_mask,
    input  logic                  clr_en,
    input  logic [IDX_W-1:0]      clr_set,
    input  logic [WAYS-1:0]       clr_mask
);
    line_t           body_q  [SETS][WAYS];
    logic [WAYS-1:0] valid_q [SETS];
    logic [WAYS-1:0] valid_d [SETS];

    always_ff @(posedge clk) begin
        if (wr_en) body_q[wr_set][wr_way] <= wr_line;
    end

    // clears first, then the fill sets its bit, so a fill beats any clear
    always_comb begin
        for (int s = 0; s < SETS; s++) begin
            valid_d[s] = valid_q[s];
            if (inv_en && inv_set == IDX_W'(s)) valid_d[s] = valid_d[s] & ~inv_mask;
            if (clr_en && clr_set == IDX_W'(s)) valid_d[s] = valid_d[s] & ~clr_mask;
            if (wr_en && wr_set == IDX_W'(s))   valid_d[s][wr_way] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
        end else begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= valid_d[s];
        end
    end

    // read ports present the pre-write contents of the addressed set
    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign rd_ways[w] = {valid_q[rd_set][w], body_q[rd_set][w]};
    end

    assert_fill_sets_valid_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> valid_q[$past(wr_set)][$past(wr_way)]);

    assert_inv_clears_R10: assert property (@(posedge clk) disable iff (rst)
        inv_en && !(wr_en && wr_set == inv_set)
        |=> (valid_q[$past(inv_set)] & $past(inv_mask)) == '0);

    assert_conflict_clears_R6: assert property (@(posedge clk) disable iff (rst)
        clr_en && !(wr_en && wr_set == clr_set)
        |=> (valid_q[$past(clr_set)] & $past(clr_mask)) == '0);
endmodule

// File: rtl/uopc_way_cmp.sv
module uopc_way_cmp
    import uopc_pkg::*;
(
    input  way_view_t        way,
    input  logic [TAG_W-1:0] tag,
    input  logic [OFF_W-1:0] off,
    output cmp_t             res
);
    logic [LEN_W-1:0] run_end;
    logic [LEN_W-1:0] off_x;
    logic [LEN_W-1:0] start_x;
    logic             found;
    logic [SLOT_W-1:0] found_slot;

    assign start_x = {1'b0, way.body.start};
    assign off_x   = {1'b0, off};
    assign run_end = start_x + way.body.len;

    // scan from the top slot down so the lowest matching slot wins
    always_comb begin
        found      = 1'b0;
        found_slot = '0;
        for (int i = UOPS - 1; i >= 0; i--) begin
            if (CNT_W'(i) < way.body.cnt && way.body.offs[i] == off) begin
                found      = 1'b1;
                found_slot = SLOT_W'(i);
            end
        end
    end

    always_comb begin
        res.tag_eq   = way.valid && (way.body.tag == tag);
        res.in_range = res.tag_eq && (off_x >= start_x) && (off_x < run_end);
        res.hit      = res.in_range && found;
        res.slot     = found_slot;
    end
endmodule

// File: rtl/uopc_pick.sv
module uopc_pick
    import uopc_pkg::*;
(
    input  way_view_t [WAYS-1:0] ways,
    input  cmp_t      [WAYS-1:0] cmps,
    output logic                 hit,
    output logic [WAY_W-1:0]     way,
    output logic [SLOT_W-1:0]    slot,
    output logic [CNT_W-1:0]     cnt,
    output slot_uops_t           lanes,
    output logic                 conflict,
    output logic [WAYS-1:0]      clr_mask
);
    line_t sel;
    logic  any_range;

    always_comb begin
        hit = 1'b0;
        way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (cmps[w].hit) begin
                hit = 1'b1;
                way = WAY_W'(w);
            end
        end
    end

    assign sel  = ways[way].body;
    assign slot = hit ? cmps[way].slot : '0;
    assign cnt  = hit ? (sel.cnt - CNT_W'(slot)) : '0;

    // lane j carries slot (slot + j) while that slot is below the count
    always_comb begin
        for (int j = 0; j < UOPS; j++) begin
            lanes[j] = '0;
            if (hit && (int'(slot) + j) < UOPS && (int'(slot) + j) < int'(sel.cnt))
                lanes[j] = sel.uops[int'(slot) + j];
        end
    end

    always_comb begin
        any_range = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            any_range   = any_range | cmps[w].in_range;
            clr_mask[w] = cmps[w].tag_eq;
        end
    end

    assign conflict = !hit && any_range;
endmodule

// File: rtl/uop_cache_lookup.sv
module uop_cache_lookup
    import uopc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic [VA_W-1:0]         req_addr,
    input  logic                    fill_valid,
    input  logic [IDX_W-1:0]        fill_set,
    input  logic [WAY_W-1:0]        fill_way,
    input  logic [TAG_W-1:0]        fill_tag,
    input  logic [OFF_W-1:0]        fill_start,
    input  logic [LEN_W-1:0]        fill_len,
    input  logic [CNT_W-1:0]        fill_cnt,
    input  logic [UOPS*OFF_W-1:0]   fill_offs,
    input  logic [UOPS*UOP_W-1:0]   fill_uops,
    input  logic                    inv_valid,
    input  logic [IDX_W-1:0]        inv_set,
    input  logic [WAYS-1:0]         inv_way_mask,
    output logic                    rsp_valid,
    output logic                    rsp_hit,
    output logic [WAY_W-1:0]        rsp_way,
    output logic [SLOT_W-1:0]       rsp_slot,
    output logic [CNT_W-1:0]        rsp_uop_cnt,
    output logic [UOPS*UOP_W-1:0]   rsp_uops
);
    logic [IDX_W-1:0]     q_set;
    logic [TAG_W-1:0]     q_tag;
    logic [OFF_W-1:0]     q_off;
    way_view_t [WAYS-1:0] set_ways;
    cmp_t      [WAYS-1:0] cmps;
    line_t                fill_line;
    logic                 p_hit;
    logic [WAY_W-1:0]     p_way;
    logic [SLOT_W-1:0]    p_slot;
    logic [CNT_W-1:0]     p_cnt;
    slot_uops_t           p_lanes;
    logic                 p_conflict;
    logic [WAYS-1:0]      p_clr_mask;
    logic                 conf_valid;

    assign q_set = addr_set(req_addr);
    assign q_tag = addr_tag(req_addr);
    assign q_off = addr_off(req_addr);

    assign fill_line.tag   = fill_tag;
    assign fill_line.start = fill_start;
    assign fill_line.len   = fill_len;
    assign fill_line.cnt   = fill_cnt;
    assign fill_line.offs  = fill_offs;
    assign fill_line.uops  = fill_uops;

    assign conf_valid = req_valid && p_conflict;

    uopc_store u_store (
        .clk      (clk),
        .rst      (rst),
        .rd_set   (q_set),
        .rd_ways  (set_ways),
        .wr_en    (fill_valid),
        .wr_set   (fill_set),
        .wr_way   (fill_way),
        .wr_line  (fill_line),
        .inv_en   (inv_valid),
        .inv_set  (inv_set),
        .inv_mask (inv_way_mask),
        .clr_en   (conf_valid),
        .clr_set  (q_set),
        .clr_mask (p_clr_mask)
    );

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        uopc_way_cmp u_cmp (
            .way (set_ways[w]),
            .tag (q_tag),
            .off (q_off),
            .res (cmps[w])
        );
    end

    uopc_pick u_pick (
        .ways     (set_ways),
        .cmps     (cmps),
        .hit      (p_hit),
        .way      (p_way),
        .slot     (p_slot),
        .cnt      (p_cnt),
        .lanes    (p_lanes),
        .conflict (p_conflict),
        .clr_mask (p_clr_mask)
    );

    always_ff @(posedge clk) begin
        if (rst || !req_valid) begin
            rsp_valid   <= 1'b0;
            rsp_hit     <= 1'b0;
            rsp_way     <= '0;
            rsp_slot    <= '0;
            rsp_uop_cnt <= '0;
            rsp_uops    <= '0;
        end else begin
            rsp_valid   <= 1'b1;
            rsp_hit     <= p_hit;
            rsp_way     <= p_way;
            rsp_slot    <= p_slot;
            rsp_uop_cnt <= p_cnt;
            rsp_uops    <= p_lanes;
        end
    end

    assert_req_gives_rsp_R3: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_idle_no_rsp_R3: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    assert_miss_no_uops_R5: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_hit |-> rsp_uop_cnt == '0 && rsp_uops == '0);

    assert_hit_count_R5: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> rsp_uop_cnt != '0 && rsp_uop_cnt <= CNT_W'(UOPS));

    assert_conflict_miss_R6: assert property (@(posedge clk) disable iff (rst)
        conf_valid |=> rsp_valid && !rsp_hit);
endmodule

// File: tb/uop_cache_lookup_bench.sv
`timescale 1ns/1ps
module uop_cache_lookup_bench;
    import uopc_pkg::*;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  req_valid = 1'b0;
    logic [VA_W-1:0]       req_addr = '0;
    logic                  fill_valid = 1'b0;
    logic [IDX_W-1:0]      fill_set = '0;
    logic [WAY_W-1:0]      fill_way = '0;
    logic [TAG_W-1:0]      fill_tag = '0;
    logic [OFF_W-1:0]      fill_start = '0;
    logic [LEN_W-1:0]      fill_len = '0;
    logic [CNT_W-1:0]      fill_cnt = '0;
    logic [UOPS*OFF_W-1:0] fill_offs = '0;
    logic [UOPS*UOP_W-1:0] fill_uops = '0;
    logic                  inv_valid = 1'b0;
    logic [IDX_W-1:0]      inv_set = '0;
    logic [WAYS-1:0]       inv_way_mask = '0;
    logic                  rsp_valid;
    logic                  rsp_hit;
    logic [WAY_W-1:0]      rsp_way;
    logic [SLOT_W-1:0]     rsp_slot;
    logic [CNT_W-1:0]      rsp_uop_cnt;
    logic [UOPS*UOP_W-1:0] rsp_uops;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    uop_cache_lookup u_uop_cache_lookup (.*);

    // reference model
    bit               m_val  [SETS][WAYS];
    logic [TAG_W-1:0] m_tag  [SETS][WAYS];
    int               m_start[SETS][WAYS];
    int               m_len  [SETS][WAYS];
    int               m_cnt  [SETS][WAYS];
    int               m_off  [SETS][WAYS][UOPS];
    logic [UOP_W-1:0] m_uop  [SETS][WAYS][UOPS];

    logic [TAG_W-1:0] pool [3] = '{38'h1, 38'h2A5, 38'h3F_0000_0001};

    function automatic logic [VA_W-1:0] mk_addr(logic [TAG_W-1:0] t, int s, int off);
        return {t, IDX_W'(s), OFF_W'(off)};
    endfunction

    task automatic predict(input int s, input logic [TAG_W-1:0] t, input int off,
                           output bit h, output int w_o, output int sl_o, output int c_o,
                           output logic [UOPS*UOP_W-1:0] u_o, output bit [WAYS-1:0] clr);
        bit any_in = 0;
        h = 0; w_o = 0; sl_o = 0; c_o = 0; u_o = '0; clr = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (m_val[s][w] && m_tag[s][w] == t) begin
                clr[w] = 1'b1;
                if (off >= m_start[s][w] && off < m_start[s][w] + m_len[s][w]) begin
                    any_in = 1;
                    for (int i = 0; i < m_cnt[s][w]; i++) begin
                        if (!h && m_off[s][w][i] == off) begin
                            h = 1; w_o = w; sl_o = i;
                        end
                    end
                end
            end
        end
        if (h) begin
            c_o = m_cnt[s][w_o] - sl_o;
            for (int j = 0; j < UOPS; j++)
                if (sl_o + j < m_cnt[s][w_o]) u_o[j*UOP_W +: UOP_W] = m_uop[s][w_o][sl_o + j];
        end
        if (h || !any_in) clr = '0;
    endtask

    task automatic set_fill(int s, int w, logic [TAG_W-1:0] t, int st, int ln, int c,
                            logic [UOPS*OFF_W-1:0] offs, logic [UOPS*UOP_W-1:0] uops);
        fill_set = IDX_W'(s); fill_way = WAY_W'(w); fill_tag = t;
        fill_start = OFF_W'(st); fill_len = LEN_W'(ln); fill_cnt = CNT_W'(c);
        fill_offs = offs; fill_uops = uops;
    endtask

    task automatic check(bit ok, string req, string act, string exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %s expected %s", req, act, exp);
        end
    endtask

    // one cycle of stimulus; called at a falling edge
    task automatic step(bit do_req, logic [VA_W-1:0] a, bit do_fill, bit do_inv, string req);
        bit h; int w; int sl; int c; logic [UOPS*UOP_W-1:0] u; bit [WAYS-1:0] clr;
        int s;
        s = int'(addr_set(a));
        req_valid = do_req; req_addr = a; fill_valid = do_fill; inv_valid = do_inv;
        if (do_req) predict(s, addr_tag(a), int'(addr_off(a)), h, w, sl, c, u, clr);
        @(posedge clk); #1;
        if (do_req) begin
            check(rsp_valid === 1'b1 && rsp_hit === h && int'(rsp_way) == w &&
                  int'(rsp_slot) == sl && int'(rsp_uop_cnt) == c && rsp_uops === u, req,
                  $sformatf("v%0b h%0b w%0d s%0d c%0d u%h", rsp_valid, rsp_hit, rsp_way,
                            rsp_slot, rsp_uop_cnt, rsp_uops),
                  $sformatf("v1 h%0b w%0d s%0d c%0d u%h", h, w, sl, c, u));
            for (int k = 0; k < WAYS; k++) if (clr[k]) m_val[s][k] = 0;
        end
        if (do_inv)
            for (int k = 0; k < WAYS; k++) if (inv_way_mask[k]) m_val[int'(inv_set)][k] = 0;
        if (do_fill) begin
            int fs = int'(fill_set); int fw = int'(fill_way);
            m_val[fs][fw] = 1; m_tag[fs][fw] = fill_tag;
            m_start[fs][fw] = int'(fill_start); m_len[fs][fw] = int'(fill_len);
            m_cnt[fs][fw] = int'(fill_cnt);
            for (int i = 0; i < UOPS; i++) begin
                m_off[fs][fw][i] = int'(fill_offs[i*OFF_W +: OFF_W]);
                m_uop[fs][fw][i] = fill_uops[i*UOP_W +: UOP_W];
            end
        end
        @(negedge clk);
        req_valid = 0; fill_valid = 0; inv_valid = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [TAG_W-1:0] ta = 38'h123;
        logic [TAG_W-1:0] tb = 38'h456;
        void'($urandom(32'd20240611));
        for (int s = 0; s < SETS; s++) for (int w = 0; w < WAYS; w++) m_val[s][w] = 0;
        repeat (3) @(posedge clk);
        #1;
        check(rsp_valid === 1'b0, "R1", $sformatf("%b", rsp_valid), "0");
        @(negedge clk); rst = 0;
        check(rsp_valid === 1'b0, "R1", $sformatf("%b", rsp_valid), "0");
        step(1, mk_addr(ta, 5, 7), 0, 0, "R1 lookup after reset");

        // R9: fill and lookup of the same set in one cycle
        set_fill(5, 3, ta, 4, 12, 3, {15'h0, 5'd11, 5'd7, 5'd4},
                 {48'h0, 16'hAAA3, 16'hAAA2, 16'hAAA1});
        step(1, mk_addr(ta, 5, 7), 1, 0, "R9 lookup sees old contents");
        // R8, R3, R4, R5, R11: unaligned hit in mid-way slot
        step(1, mk_addr(ta, 5, 7), 0, 0, "R8 R11 R4 R5 hit at slot 1");
        step(1, mk_addr(ta, 5, 4), 0, 0, "R3 hit at run start");
        step(1, mk_addr(tb, 5, 7), 0, 0, "R2 other tag misses");
        step(1, mk_addr(ta, 6, 7), 0, 0, "R2 other set misses");

        set_fill(5, 6, tb, 0, 32, 1, '0, {80'h0, 16'hBBB0});
        step(0, '0, 1, 0, "fill");
        set_fill(5, 0, ta, 20, 8, 2, {20'h0, 5'd24, 5'd20}, {64'h0, 16'hCCC1, 16'hCCC0});
        step(0, '0, 1, 0, "fill");
        step(1, mk_addr(ta, 5, 24), 0, 0, "R4 R5 last slot");
        // R6: offset inside a run but not on a start
        step(1, mk_addr(ta, 5, 8), 0, 0, "R6 conflict miss");
        step(1, mk_addr(ta, 5, 4), 0, 0, "R6 dropped way misses");
        step(1, mk_addr(ta, 5, 20), 0, 0, "R6 same-tag way dropped");
        step(1, mk_addr(tb, 5, 0), 0, 0, "R7 other tag kept");

        // R3: count zero never hits; run end is exclusive
        set_fill(7, 1, ta, 0, 32, 0, '0, '1);
        step(0, '0, 1, 0, "fill");
        step(1, mk_addr(ta, 7, 0), 0, 0, "R3 count zero misses");
        set_fill(8, 2, ta, 8, 4, 6, {5'd12, 5'd11, 5'd10, 5'd9, 5'd9, 5'd8},
                 {16'h6, 16'h5, 16'h4, 16'h3, 16'h2, 16'h1});
        step(0, '0, 1, 0, "fill");
        step(1, mk_addr(ta, 8, 12), 0, 0, "R3 run end excluded");
        step(1, mk_addr(ta, 8, 9), 0, 0, "R4 lowest duplicate slot");

        // R10: invalidate port, and fill beating it
        inv_set = 5; inv_way_mask = 8'b0100_0000;
        step(0, '0, 0, 1, "inv");
        step(1, mk_addr(tb, 5, 0), 0, 0, "R10 cleared way misses");
        inv_set = 8; inv_way_mask = 8'b0000_0100;
        set_fill(8, 2, tb, 0, 2, 1, {25'h0, 5'd1}, {80'h0, 16'h7777});
        step(0, '0, 1, 1, "fill+inv");
        step(1, mk_addr(tb, 8, 1), 0, 0, "R10 fill wins over clear");

        // constrained random traffic on a few sets and tags
        for (int n = 0; n < 4000; n++) begin
            int r = $urandom % 100;
            int s = $urandom % 4;
            int w = $urandom % WAYS;
            bit do_req = 0, do_fill = 0, do_inv = 0;
            logic [VA_W-1:0] a = '0;
            if (r < 35 || (r >= 80 && r < 92)) begin
                int st = $urandom % 32;
                int ln = 1 + ($urandom % (32 - st));
                logic [UOPS*OFF_W-1:0] offs;
                logic [UOPS*UOP_W-1:0] uops;
                for (int i = 0; i < UOPS; i++) begin
                    offs[i*OFF_W +: OFF_W] = OFF_W'(st + ($urandom % ln));
                    uops[i*UOP_W +: UOP_W] = UOP_W'($urandom);
                end
                set_fill($urandom % 4, $urandom % WAYS, pool[$urandom % 3], st, ln,
                         $urandom % (UOPS + 1), offs, uops);
                do_fill = 1;
            end
            if (r >= 35 && r < 92) begin
                if (m_val[s][w] && m_cnt[s][w] > 0 && ($urandom % 3) != 0)
                    a = mk_addr(m_tag[s][w], s, m_off[s][w][$urandom % m_cnt[s][w]]);
                else
                    a = mk_addr(pool[$urandom % 3], s, $urandom % 32);
                do_req = 1;
            end
            if (r >= 92) begin
                inv_set = IDX_W'($urandom % 4);
                inv_way_mask = WAYS'($urandom);
                do_inv = 1;
            end
            step(do_req, a, do_fill, do_inv, "R3 R4 R5 R6 R7 R8 R9 random");
        end
        finish_run();
    end
endmodule